// File: doc/BRIEF.md
# Key-Sequenced Watchdog Controller

This block watches the 64-bit count built from both halves of a general-purpose timer pair and asks for a system reset when software stops servicing it. Software controls it through one 32-bit write port. Each write carries a 16-bit key in the upper half and an enable flag at bit 14. The controller starts out disabled. It becomes active only after two different keys arrive in a fixed order, each written with the enable flag set.

Once active, the controller cannot be turned off by software. A service is the first key followed by the second key. A service makes the controller pulse a clear strobe, and the surrounding timer uses that strobe to reset its 64-bit count to zero. Two events raise a one-cycle reset request: a write whose key is neither valid key, or the count becoming equal to the 64-bit period. The controller then stays tripped until the system reset returns it to the disabled state.

Nothing happens unless the timer pair is in its watchdog mode (mode code 2) and both halves have been released from reset.

Top module: `wdk_ctrl`

## Requirements
- R1: After a synchronous reset, the controller reports state code 0 (disabled), and `rst_req` and `cnt_clr` are both 0.
- R2: While disabled, a write with key 0xA5C6 in bits 31:16 and bit 14 set moves the state to code 1 (pre-active) on the next clock. The same key with bit 14 clear is ignored.
- R3: While pre-active, a write with key 0xDA7E and bit 14 set moves the state to code 2 (active).
- R4: While disabled or pre-active, a write with any other key or enable combination never raises `rst_req`. A pre-active controller falls back to disabled, and a disabled controller stays disabled. A repeat of the first key with bit 14 set keeps the pre-active state.
- R5: While active, a write whose key is neither 0xA5C6 nor 0xDA7E raises `rst_req` on the next clock and moves the state to code 3 (tripped). 0x00004000 is such a write.
- R6: While active, a write of key 0xA5C6 followed later by a write of key 0xDA7E pulses `cnt_clr` for one cycle after the second write, with no reset request. Key 0xDA7E without a preceding 0xA5C6 clears nothing.
- R7: While active, `cnt` equal to `prd` raises `rst_req` on the next clock and enters the tripped state.
- R8: When the mode input is not 2, or either half is still held in reset, writes and count matches have no effect on the state or on either strobe.
- R9: While active, a valid key written with bit 14 clear leaves the controller active. Only the system reset leaves the active state.
- R10: `rst_req` lasts exactly one cycle. In the tripped state, further bad keys and count matches raise no request until the system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word: key in 31:16, enable in 14 |
| tmr_mode | input | 2 | Global timer mode field of the pair |
| lo_run | input | 1 | Lower half released from reset |
| hi_run | input | 1 | Upper half released from reset |
| cnt | input | 64 | Current 64-bit count |
| prd | input | 64 | 64-bit period |
| rst_req | output | 1 | One-cycle system reset request |
| cnt_clr | output | 1 | One-cycle request to clear the 64-bit count |
| wd_state | output | 2 | 0 disabled, 1 pre-active, 2 active, 3 tripped |

## Verification
Some properties are checked on every cycle: the single-cycle reset pulse, the tripped state holding, the absence of requests from the disabled and pre-active states, the frozen state while the mode gate is closed, and the clear strobe appearing only while active. Only the bench's scenarios can show the key ordering itself. That covers the arming sequence, the fallback from pre-active, service pairs split by other writes, and the exact cycle in which a count match or a bad key turns into a reset. These are compared against a cycle model over directed and random write streams.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_PRE   = 2'd1,
        WD_LIVE  = 2'd2,
        WD_TRIP  = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic wr;
        logic en;
        logic is_a;
        logic is_b;
    } wr_cls_t;

    function automatic logic key_bad(input wr_cls_t c);
        return c.wr && !c.is_a && !c.is_b;
    endfunction

endpackage

// File: rtl/wdk_keydec.sv
module wdk_keydec
    import wdk_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int KEY_W   = 16,
    parameter int KEY_LSB = 16,
    parameter int EN_BIT  = 14,
    parameter logic [KEY_W-1:0] KEY_A = 'hA5C6,
    parameter logic [KEY_W-1:0] KEY_B = 'hDA7E
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output wr_cls_t           cls
);
    logic [KEY_W-1:0] key;
    logic             unused_bits;

    assign key         = wr_data[KEY_LSB +: KEY_W];
    assign unused_bits = ^wr_data;

    always_comb begin
        cls.wr   = wr_en;
        cls.en   = wr_data[EN_BIT];
        cls.is_a = (key == KEY_A);
        cls.is_b = (key == KEY_B);
    end

    always_comb begin
        assert (!(cls.is_a && cls.is_b))
            else $error("p_keys_distinct_r5: both keys decoded at once");
    end
endmodule

// File: rtl/wdk_expiry.sv
module wdk_expiry #(
    parameter int CNT_W = 64,
    parameter int SEG_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] prd,
    output logic             hit
);
    localparam int NSEG = (CNT_W + SEG_W - 1) / SEG_W;

    logic [NSEG-1:0] seg_eq;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam int LO = g * SEG_W;
        localparam int HI = ((LO + SEG_W) > CNT_W) ? (CNT_W - 1) : (LO + SEG_W - 1);
        assign seg_eq[g] = (cnt[HI:LO] == prd[HI:LO]);
    end

    assign hit = &seg_eq;
endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm
    import wdk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      gate_ok,
    input  wr_cls_t   cls,
    input  logic      hit,
    output wd_state_e state,
    output logic      rst_req,
    output logic      cnt_clr
);
    wd_state_e st_n;
    logic      armed, armed_n;
    logic      req_n, clr_n;

    always_comb begin
        st_n    = state;
        armed_n = armed;
        req_n   = 1'b0;
        clr_n   = 1'b0;
        if (gate_ok) begin
            unique case (state)
                WD_OFF: begin
                    if (cls.wr && cls.en && cls.is_a) st_n = WD_PRE;
                end
                WD_PRE: begin
                    if (cls.wr) begin
                        if (cls.en && cls.is_b) begin
                            st_n    = WD_LIVE;
                            armed_n = 1'b0;
                        end else if (!(cls.en && cls.is_a)) begin
                            st_n = WD_OFF;
                        end
                    end
                end
                WD_LIVE: begin
                    if (key_bad(cls) || hit) begin
                        st_n    = WD_TRIP;
                        req_n   = 1'b1;
                        armed_n = 1'b0;
                    end else if (cls.wr) begin
                        if (cls.is_a) begin
                            armed_n = 1'b1;
                        end else if (cls.is_b) begin
                            clr_n   = armed;
                            armed_n = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WD_OFF;
            armed   <= 1'b0;
            rst_req <= 1'b0;
            cnt_clr <= 1'b0;
        end else begin
            state   <= st_n;
            armed   <= armed_n;
            rst_req <= req_n;
            cnt_clr <= clr_n;
        end
    end

    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    p_trip_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state == WD_TRIP) |=> (state == WD_TRIP) && !rst_req);
    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (state == WD_OFF || state == WD_PRE) |=> !rst_req);
    p_gate_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        !gate_ok |=> $stable(state) && !rst_req && !cnt_clr);
    p_clr_live_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |-> (state == WD_LIVE));
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (state == WD_LIVE) |=> (state == WD_LIVE || state == WD_TRIP));
    p_req_trip_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (state == WD_TRIP));
endmodule

// File: rtl/wdk_ctrl.sv
module wdk_ctrl
    import wdk_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int KEY_W   = 16,
    parameter int KEY_LSB = 16,
    parameter int EN_BIT  = 14,
    parameter int CNT_W   = 64,
    parameter int SEG_W   = 16,
    parameter int MODE_W  = 2,
    parameter logic [MODE_W-1:0] WD_MODE = 'd2,
    parameter logic [KEY_W-1:0]  KEY_A   = 'hA5C6,
    parameter logic [KEY_W-1:0]  KEY_B   = 'hDA7E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MODE_W-1:0] tmr_mode,
    input  logic              lo_run,
    input  logic              hi_run,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  prd,
    output logic              rst_req,
    output logic              cnt_clr,
    output logic [1:0]        wd_state
);
    wr_cls_t   cls;
    logic      hit;
    logic      gate_ok;
    wd_state_e state;

    assign gate_ok  = (tmr_mode == WD_MODE) && lo_run && hi_run;
    assign wd_state = state;

    wdk_keydec #(
        .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_LSB(KEY_LSB),
        .EN_BIT(EN_BIT), .KEY_A(KEY_A), .KEY_B(KEY_B)
    ) u_dec (
        .wr_en(wr_en), .wr_data(wr_data), .cls(cls)
    );

    wdk_expiry #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_exp (
        .cnt(cnt), .prd(prd), .hit(hit)
    );

    wdk_fsm u_fsm (
        .clk(clk), .rst(rst), .gate_ok(gate_ok), .cls(cls), .hit(hit),
        .state(state), .rst_req(rst_req), .cnt_clr(cnt_clr)
    );
endmodule

// File: tb/sim_wdk_ctrl.sv
module sim_wdk_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  tmr_mode = 2'd2;
    logic        lo_run = 1'b1, hi_run = 1'b1;
    logic [63:0] cnt = 64'd1, prd = 64'd1000;
    logic        rst_req, cnt_clr;
    logic [1:0]  wd_state;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    int m_state = 0;
    bit m_armed = 1'b0, e_req = 1'b0, e_clr = 1'b0;

    localparam logic [15:0] KA = 16'hA5C6, KB = 16'hDA7E;

    always #4 clk = ~clk;

    wdk_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tmr_mode(tmr_mode), .lo_run(lo_run), .hi_run(hi_run),
        .cnt(cnt), .prd(prd), .rst_req(rst_req), .cnt_clr(cnt_clr),
        .wd_state(wd_state)
    );

    function automatic logic [31:0] kw(input logic [15:0] k, input bit en);
        return {k, 1'b0, en, 14'h0};
    endfunction

    task automatic model();
        logic [15:0] k = wr_data[31:16];
        bit en = wr_data[14];
        bit a = (k == KA), b = (k == KB);
        e_req = 0; e_clr = 0;
        if (rst) begin
            m_state = 0; m_armed = 0;
        end else if (tmr_mode == 2'd2 && lo_run && hi_run) begin
            case (m_state)
                0: if (wr_en && en && a) m_state = 1;
                1: if (wr_en) begin
                       if (en && b) begin m_state = 2; m_armed = 0; end
                       else if (!(en && a)) m_state = 0;
                   end
                2: if ((wr_en && !a && !b) || cnt == prd) begin
                       m_state = 3; e_req = 1; m_armed = 0;
                   end else if (wr_en) begin
                       if (a) m_armed = 1;
                       else if (b) begin e_clr = m_armed; m_armed = 0; end
                   end
                default: ;
            endcase
        end
    endtask

    task automatic step(input bit we, input logic [31:0] d, input string tag);
        @(negedge clk);
        wr_en = we; wr_data = d;
        model();
        @(posedge clk);
        #2;
        checks++;
        if (wd_state !== m_state[1:0] || rst_req !== e_req || cnt_clr !== e_clr) begin
            errors++;
            $display("FAIL %s: actual state=%0d req=%0b clr=%0b expected state=%0d req=%0b clr=%0b",
                     tag, wd_state, rst_req, cnt_clr, m_state, e_req, e_clr);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(0, 0, "R1");
        step(0, 0, "R1");
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd31));
        do_reset();
        step(0, 0, "R1");
        // R2: enable bit required
        step(1, kw(KA, 0), "R2");
        step(1, kw(KA, 1), "R2");
        step(1, kw(KA, 1), "R4");
        // R4: unexpected key in pre-active falls back, no reset
        step(1, kw(16'h1234, 1), "R4");
        step(1, kw(KB, 1), "R4");
        step(1, 32'h0000_4000, "R4");
        // R3: arm
        step(1, kw(KA, 1), "R2");
        step(1, kw(KB, 1), "R3");
        // R6/R9: service with enable clear, stays active
        step(1, kw(KA, 0), "R9");
        step(0, 0, "R6");
        step(1, kw(KB, 0), "R6");
        step(0, 0, "R6");
        step(1, kw(KB, 1), "R6");
        // R8: gate closed
        tmr_mode = 2'd1;
        step(1, 32'h0000_4000, "R8");
        tmr_mode = 2'd2; lo_run = 1'b0; cnt = prd;
        step(1, kw(16'h0, 1), "R8");
        lo_run = 1'b1; hi_run = 1'b0;
        step(0, 0, "R8");
        hi_run = 1'b1; cnt = 64'd1;
        // R5: bad key trips
        step(1, 32'h0000_4000, "R5");
        step(0, 0, "R10");
        step(1, 32'h0000_4000, "R10");
        cnt = prd;
        step(0, 0, "R10");
        cnt = 64'd1;
        // R7: count match
        do_reset();
        step(1, kw(KA, 1), "R2");
        step(1, kw(KB, 1), "R3");
        cnt = 64'hFFFF_0000_0000_0005; prd = 64'hFFFF_0000_0000_0006;
        step(0, 0, "R7");
        cnt = prd;
        step(0, 0, "R7");
        step(0, 0, "R10");
        cnt = 64'd1; prd = 64'd1000;
        do_reset();
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom % 8;
            logic [15:0] k = (sel < 3) ? KA : (sel < 6) ? KB : 16'($urandom);
            rst = ($urandom % 150 == 0);
            tmr_mode = ($urandom % 10 == 0) ? 2'($urandom) : 2'd2;
            lo_run = ($urandom % 20 != 0);
            hi_run = ($urandom % 20 != 0);
            prd = {$urandom, $urandom};
            cnt = ($urandom % 64 == 0) ? prd : {$urandom, $urandom};
            step($urandom % 2 == 0, {k, 16'($urandom)}, "R2/R3/R4/R5/R6/R7 random");
        end
        rst = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule